// File: doc/BRIEF.md
# Power-Management Function Configuration Core

This block is the power-management function of a south bridge, seen from its PCI configuration space and from a small byte-wide event register window. It holds the 32-bit power-management I/O base and its enable byte, and the SMBus I/O base and its enable byte. It applies the write masking rules on the SMBus registers and drives the decode enables and base addresses to the I/O decoder next to it.

Behind the power-management I/O window it keeps a 16-bit event status register, a 16-bit event enable register and a free-running timer. Hardware event pulses set status bits, and software clears them by writing ones. A level interrupt (SCI) is raised while any of four enabled sources is pending: timer, global lock, power button or real-time clock. The window takes single-byte accesses only, and only while power-management decoding is enabled.

Top module: `pmf_core`

## Requirements
- R1: After reset, dword 0x00 reads {DEVICE_ID, VENDOR_ID}, dword 0x04 reads 0x02800000 (command 0, status: fast back-to-back bit 7 and medium DEVSEL in bits 10:9 = 01), 0x40 reads 0, 0x48 reads 0x00000001, 0x80 reads 0, 0x90 reads 0x00000001 and 0xD0 reads 0. Both decode enables, `sci` and the status and enable registers are 0.
- R2: A config write updates only the byte lanes whose `cfg_be` bit is set. This holds for the PM base (dword 0x40) and the auxiliary dword 0x48. In dword 0x80 only byte 0 is stored, and the other lanes read 0.
- R3: `pm_dec_en` equals bit 0 of config byte 0x80, and `pm_io_base` equals dword 0x40.
- R4: A write to dword 0x90 with any lane enabled merges the lanes and then stores (merged AND 0x0000FFF0) OR 1. A write with `cfg_be` = 0 changes nothing.
- R5: A write to dword 0xD0 with lane 2 enabled stores only the low four bits of byte 0xD2. Lanes 0, 1 and 3 of that dword are ignored and read 0. `smb_dec_en` is bit 0 of byte 0xD2, and `smb_io_base` is the SMBus base with its low nibble cleared.
- R6: The command word (bits 15:0 of dword 0x04) is writable per lane. The status half is read-only, and dword 0x00 is read-only.
- R7: An `evt_set` pulse sets the matching status bit. Writing window offset 0 clears status bits 7:0 where the data has ones, and offset 1 does the same for bits 15:8. Zero bits leave status unchanged. A set and a clear of the same bit in one cycle leave the bit set.
- R8: The enable register is read and written at window offsets 2 (bits 7:0) and 3 (bits 15:8).
- R9: `sci` is high exactly when (status AND enable) has any of bits 0, 5, 8 or 10 set. Other bits, such as bit 9, never raise it. A clearing write lowers `sci` directly after the clock edge that takes the write.
- R10: The timer is a TMR_W-bit counter that increments every clock. It reads little-endian at offsets 4 to 6, with bits above TMR_W reading 0. Its wrap from all ones to zero sets status bit 0 at the same edge.
- R11: `tmr_arm` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R12: A window access takes effect only when `io_size` is 0 (one byte) and `pm_dec_en` is 1. Otherwise writes are ignored and reads return 0.
- R13: Config dwords not listed in R1 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_dw | input | 6 | Config dword index (byte offset bits 7:2) |
| cfg_be | input | 4 | Config write byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_dw` |
| io_req | input | 1 | Event window access request |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_off | input | 3 | Byte offset in the event window |
| io_wdata | input | 8 | Window write data |
| io_rdata | output | 8 | Window read data |
| evt_set | input | 16 | Hardware event pulses, one per status bit |
| pm_dec_en | output | 1 | Power-management I/O decode enable |
| pm_io_base | output | 32 | Power-management I/O base |
| smb_dec_en | output | 1 | SMBus I/O decode enable |
| smb_io_base | output | 16 | SMBus I/O base, low nibble zero |
| sci | output | 1 | Level interrupt |
| tmr_arm | output | 1 | Timer wake armed |

## Verification
The bench builds the core with TMR_W = 8, so the timer wraps every 256 cycles. The status-set-on-wrap path, the timer-read-zero corner and the arm flag going low and then high again can all be reached inside a few hundred cycles. Non-default vendor and device IDs make the read-only ID dword tell apart from reset zeros. The 24-bit default differs only in how far the counter runs before it wraps, and in how many window bytes carry counter bits.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    localparam int CFG_DW_W  = 6;
    localparam int IO_OFF_W  = 3;
    localparam int EVT_W     = 16;
    localparam int TMR_EXT_W = 24;

    // config dword indices (byte offset >> 2)
    localparam logic [CFG_DW_W-1:0] DW_ID      = 6'h00;
    localparam logic [CFG_DW_W-1:0] DW_CMDSTS  = 6'h01;
    localparam logic [CFG_DW_W-1:0] DW_PMBASE  = 6'h10;
    localparam logic [CFG_DW_W-1:0] DW_PMAUX   = 6'h12;
    localparam logic [CFG_DW_W-1:0] DW_PMCTL   = 6'h20;
    localparam logic [CFG_DW_W-1:0] DW_SMBBASE = 6'h24;
    localparam logic [CFG_DW_W-1:0] DW_SMBCTL  = 6'h34;

    localparam logic [15:0] STS_FIXED     = 16'h0280;
    localparam logic [15:0] SMB_BASE_MASK = 16'hFFF0;
    localparam logic [15:0] SMB_IO_FLAG   = 16'h0001;
    localparam logic [31:0] PMAUX_INIT    = 32'h0000_0001;

    // timer, global lock, power button, real-time clock
    localparam logic [EVT_W-1:0] SCI_MASK = 16'h0521;
    localparam int TMR_STS_BIT = 0;

    typedef enum logic [IO_OFF_W-1:0] {
        OFF_STS_LO = 3'd0,
        OFF_STS_HI = 3'd1,
        OFF_EN_LO  = 3'd2,
        OFF_EN_HI  = 3'd3,
        OFF_TMR_B0 = 3'd4,
        OFF_TMR_B1 = 3'd5,
        OFF_TMR_B2 = 3'd6,
        OFF_RSVD   = 3'd7
    } io_off_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } io_size_e;

    typedef struct packed {
        logic        pm_en;
        logic [31:0] pm_base;
        logic        smb_en;
        logic [15:0] smb_base;
    } dec_t;

    typedef struct packed {
        logic       wr;
        io_off_e    off;
        logic [7:0] data;
    } io_wr_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [15:0] smb_fold(input logic [31:0] v);
        return (v[15:0] & SMB_BASE_MASK) | SMB_IO_FLAG;
    endfunction

endpackage

// File: rtl/pmf_cfg_regs.sv
module pmf_cfg_regs
    import pmf_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hFFFE,
    parameter logic [15:0] DEVICE_ID = 16'h0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_DW_W-1:0] cfg_dw,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output dec_t                dec
);

    logic [15:0] cmd_q;
    logic [31:0] pmbase_q;
    logic [31:0] pmaux_q;
    logic [7:0]  pmctl_q;
    logic [15:0] smb_q;
    logic [7:0]  smbctl_q;

    logic [31:0] cmd_merged;
    logic [15:0] smb_next;

    always_comb begin
        cmd_merged = lane_merge({16'h0, cmd_q}, cfg_wdata, {2'b00, cfg_be[1:0]});
        smb_next   = smb_fold(lane_merge({16'h0, smb_q}, cfg_wdata, cfg_be));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            pmbase_q <= '0;
            pmaux_q  <= PMAUX_INIT;
            pmctl_q  <= '0;
            smb_q    <= SMB_IO_FLAG;
            smbctl_q <= '0;
        end else if (cfg_wr) begin
            unique case (cfg_dw)
                DW_CMDSTS:  cmd_q    <= cmd_merged[15:0];
                DW_PMBASE:  pmbase_q <= lane_merge(pmbase_q, cfg_wdata, cfg_be);
                DW_PMAUX:   pmaux_q  <= lane_merge(pmaux_q, cfg_wdata, cfg_be);
                DW_PMCTL:   if (cfg_be[0]) pmctl_q <= cfg_wdata[7:0];
                DW_SMBBASE: if (|cfg_be) smb_q <= smb_next;
                DW_SMBCTL:  if (cfg_be[2]) smbctl_q <= {4'h0, cfg_wdata[19:16]};
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (cfg_dw)
            DW_ID:      cfg_rdata = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTS:  cfg_rdata = {STS_FIXED, cmd_q};
            DW_PMBASE:  cfg_rdata = pmbase_q;
            DW_PMAUX:   cfg_rdata = pmaux_q;
            DW_PMCTL:   cfg_rdata = {24'h0, pmctl_q};
            DW_SMBBASE: cfg_rdata = {16'h0, smb_q};
            DW_SMBCTL:  cfg_rdata = {8'h0, smbctl_q, 16'h0};
            default:    cfg_rdata = '0;
        endcase
    end

    always_comb begin
        dec.pm_en    = pmctl_q[0];
        dec.pm_base  = pmbase_q;
        dec.smb_en   = smbctl_q[0];
        dec.smb_base = smb_q & SMB_BASE_MASK;
    end

    // R4
    smb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_dw == DW_SMBBASE && cfg_be == 4'h0) |=> $stable(smb_q));

    // R5
    smb_ctl_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_dw == DW_SMBCTL && cfg_be[2]) |=> (smbctl_q[7:4] == 4'h0));

    // R5
    smb_ctl_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_dw == DW_SMBCTL && !cfg_be[2]) |=> $stable(smbctl_q));

endmodule

// File: rtl/pmf_timer.sv
module pmf_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TMR_W-1:0] cnt,
    output logic             carry
);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    // the edge that wraps the counter is the one that takes the carry
    assign carry = &cnt;

endmodule

// File: rtl/pmf_evt.sv
module pmf_evt
    import pmf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  io_wr_t           wr,
    input  logic [EVT_W-1:0] evt_set,
    input  logic             tmr_carry,
    output logic [EVT_W-1:0] sts,
    output logic [EVT_W-1:0] en,
    output logic             sci,
    output logic             tmr_arm
);

    logic [EVT_W-1:0] set_v;
    logic [EVT_W-1:0] clr_v;

    always_comb begin
        set_v = evt_set;
        set_v[TMR_STS_BIT] = evt_set[TMR_STS_BIT] | tmr_carry;
        clr_v = '0;
        if (wr.wr && wr.off == OFF_STS_LO) clr_v[7:0]  = wr.data;
        if (wr.wr && wr.off == OFF_STS_HI) clr_v[15:8] = wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_v) | set_v;
            if (wr.wr && wr.off == OFF_EN_LO) en[7:0]  <= wr.data;
            if (wr.wr && wr.off == OFF_EN_HI) en[15:8] <= wr.data;
        end
    end

    assign sci     = |(sts & en & SCI_MASK);
    assign tmr_arm = en[TMR_STS_BIT] & ~sts[TMR_STS_BIT];

    // R7
    sts_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.wr && wr.off == OFF_STS_LO)
        |=> ((sts[7:0] & $past(wr.data & ~set_v[7:0])) == 8'h0));

    // R7
    sts_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((sts & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/pmf_core.sv
module pmf_core
    import pmf_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hFFFE,
    parameter logic [15:0] DEVICE_ID = 16'h0001,
    parameter int          TMR_W     = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_DW_W-1:0] cfg_dw,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                io_req,
    input  logic                io_wr,
    input  logic [1:0]          io_size,
    input  logic [IO_OFF_W-1:0] io_off,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic [EVT_W-1:0]    evt_set,
    output logic                pm_dec_en,
    output logic [31:0]         pm_io_base,
    output logic                smb_dec_en,
    output logic [15:0]         smb_io_base,
    output logic                sci,
    output logic                tmr_arm
);

    dec_t             dec;
    io_wr_t           wr;
    logic             io_ok;
    logic [EVT_W-1:0] evt_sts;
    logic [EVT_W-1:0] evt_en;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_carry;
    logic [TMR_EXT_W-1:0] tmr_ext;

    pmf_cfg_regs #(
        .VENDOR_ID(VENDOR_ID),
        .DEVICE_ID(DEVICE_ID)
    ) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_dw   (cfg_dw),
        .cfg_be   (cfg_be),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .dec      (dec)
    );

    pmf_timer #(.TMR_W(TMR_W)) i_tmr (
        .clk  (clk),
        .rst  (rst),
        .cnt  (tmr_cnt),
        .carry(tmr_carry)
    );

    always_comb begin
        io_ok   = io_req && (io_size == SZ_BYTE) && dec.pm_en;
        wr.wr   = io_ok && io_wr;
        wr.off  = io_off_e'(io_off);
        wr.data = io_wdata;
    end

    pmf_evt i_evt (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .evt_set  (evt_set),
        .tmr_carry(tmr_carry),
        .sts      (evt_sts),
        .en       (evt_en),
        .sci      (sci),
        .tmr_arm  (tmr_arm)
    );

    always_comb begin
        tmr_ext = '0;
        tmr_ext[TMR_W-1:0] = tmr_cnt;
    end

    always_comb begin
        io_rdata = 8'h0;
        if (io_ok && !io_wr) begin
            unique case (io_off_e'(io_off))
                OFF_STS_LO: io_rdata = evt_sts[7:0];
                OFF_STS_HI: io_rdata = evt_sts[15:8];
                OFF_EN_LO:  io_rdata = evt_en[7:0];
                OFF_EN_HI:  io_rdata = evt_en[15:8];
                OFF_TMR_B0: io_rdata = tmr_ext[7:0];
                OFF_TMR_B1: io_rdata = tmr_ext[15:8];
                OFF_TMR_B2: io_rdata = tmr_ext[23:16];
                default:    io_rdata = 8'h0;
            endcase
        end
    end

    assign pm_dec_en   = dec.pm_en;
    assign pm_io_base  = dec.pm_base;
    assign smb_dec_en  = dec.smb_en;
    assign smb_io_base = dec.smb_base;

    // R10
    tmr_sts_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_carry |=> evt_sts[TMR_STS_BIT]);

    // R12
    io_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (io_req && io_wr && (io_size != SZ_BYTE || !pm_dec_en)) |=> $stable(evt_en));

endmodule

// File: tb/test_pmf_core.sv
module test_pmf_core;

    localparam logic [15:0] VID = 16'hA5C3;
    localparam logic [15:0] DID = 16'h0E71;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [1:0]  io_size = '0;
    logic [2:0]  io_off = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] evt_set = '0;
    logic        pm_dec_en;
    logic [31:0] pm_io_base;
    logic        smb_dec_en;
    logic [15:0] smb_io_base;
    logic        sci;
    logic        tmr_arm;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pmf_core #(.VENDOR_ID(VID), .DEVICE_ID(DID), .TMR_W(8)) i_pmf_core (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_req(io_req), .io_wr(io_wr), .io_size(io_size), .io_off(io_off),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .evt_set(evt_set),
        .pm_dec_en(pm_dec_en), .pm_io_base(pm_io_base),
        .smb_dec_en(smb_dec_en), .smb_io_base(smb_io_base),
        .sci(sci), .tmr_arm(tmr_arm)
    );

    // tag, dword, byte enables, write data, expected read-back
    localparam int NV = 13;
    localparam logic [77:0] VEC [NV] = '{
        {4'd2,  6'h10, 4'hF, 32'h0000_4001, 32'h0000_4001},
        {4'd2,  6'h10, 4'h2, 32'hAABB_CCDD, 32'h0000_CC01},
        {4'd2,  6'h12, 4'hC, 32'h1234_5678, 32'h1234_0001},
        {4'd2,  6'h20, 4'hF, 32'hFFFF_FF01, 32'h0000_0001},
        {4'd4,  6'h24, 4'hF, 32'hFFFF_ABCD, 32'h0000_ABC1},
        {4'd4,  6'h24, 4'h1, 32'h0000_0032, 32'h0000_AB31},
        {4'd4,  6'h24, 4'h0, 32'h0000_0000, 32'h0000_AB31},
        {4'd4,  6'h24, 4'h8, 32'h5500_0000, 32'h0000_AB31},
        {4'd5,  6'h34, 4'h4, 32'h00FF_0000, 32'h000F_0000},
        {4'd5,  6'h34, 4'hB, 32'hFFFF_FFFF, 32'h000F_0000},
        {4'd6,  6'h01, 4'hF, 32'hFFFF_0007, 32'h0280_0007},
        {4'd6,  6'h00, 4'hF, 32'hFFFF_FFFF, 32'h0E71_A5C3},
        {4'd13, 6'h0F, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] dw, output logic [31:0] v);
        @(negedge clk);
        cfg_dw = dw;
        #1 v = cfg_rdata;
    endtask

    task automatic io_write(input logic [2:0] off, input logic [7:0] d, input logic [1:0] sz);
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b1; io_off = off; io_wdata = d; io_size = sz;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0; io_size = '0;
    endtask

    task automatic io_read(input logic [2:0] off, input logic [1:0] sz, output logic [7:0] v);
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b0; io_off = off; io_size = sz;
        #1 v = io_rdata;
        io_req = 1'b0; io_size = '0;
    endtask

    task automatic pulse(input logic [15:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b;
        logic [7:0]  t1;
        logic        prev;
        logic        seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_read(6'h00, r); check("R1", r, {DID, VID});
        cfg_read(6'h01, r); check("R1", r, 32'h0280_0000);
        cfg_read(6'h10, r); check("R1", r, 32'h0);
        cfg_read(6'h12, r); check("R1", r, 32'h1);
        cfg_read(6'h20, r); check("R1", r, 32'h0);
        cfg_read(6'h24, r); check("R1", r, 32'h1);
        cfg_read(6'h34, r); check("R1", r, 32'h0);
        check("R1", {28'h0, pm_dec_en, smb_dec_en, sci, tmr_arm}, 32'h0);

        // config vector table
        for (int i = 0; i < NV; i++) begin
            cfg_write(VEC[i][73:68], VEC[i][67:64], VEC[i][63:32]);
            cfg_read(VEC[i][73:68], r);
            check(tag_name(VEC[i][77:74]), r, VEC[i][31:0]);
        end

        // R3 and R5 decoder outputs
        check("R3", {31'h0, pm_dec_en}, 32'h1);
        check("R3", pm_io_base, 32'h0000_CC01);
        check("R5", {31'h0, smb_dec_en}, 32'h1);
        check("R5", {16'h0, smb_io_base}, 32'h0000_AB30);

        // R8 enable register
        io_write(3'd2, 8'h20, 2'd0);
        io_write(3'd3, 8'h07, 2'd0);
        io_read(3'd2, 2'd0, b); check("R8", {24'h0, b}, 32'h20);
        io_read(3'd3, 2'd0, b); check("R8", {24'h0, b}, 32'h07);

        io_write(3'd0, 8'hFF, 2'd0);
        io_write(3'd1, 8'hFF, 2'd0);

        // R9 sleep button (bit 9) enabled but outside the interrupt subset
        pulse(16'h0200);
        io_read(3'd1, 2'd0, b); check("R7", {24'h0, b}, 32'h02);
        check("R9", {31'h0, sci}, 32'h0);

        // R9 power button raises sci
        pulse(16'h0100);
        check("R9", {31'h0, sci}, 32'h1);

        // R9 clearing write drops sci right after its edge
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b1; io_off = 3'd1; io_wdata = 8'h01; io_size = 2'd0;
        #1 check("R9", {31'h0, sci}, 32'h1);
        @(posedge clk);
        #1 check("R9", {31'h0, sci}, 32'h0);
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
        io_read(3'd1, 2'd0, b); check("R7", {24'h0, b}, 32'h02);

        // R7 set wins over clear in the same cycle
        @(negedge clk);
        evt_set = 16'h0020;
        io_req = 1'b1; io_wr = 1'b1; io_off = 3'd0; io_wdata = 8'h20; io_size = 2'd0;
        @(negedge clk);
        evt_set = '0; io_req = 1'b0; io_wr = 1'b0;
        io_read(3'd0, 2'd0, b); check("R7", {24'h0, b & 8'h20}, 32'h20);
        check("R9", {31'h0, sci}, 32'h1);
        io_write(3'd0, 8'h20, 2'd0);
        check("R9", {31'h0, sci}, 32'h0);

        // R12 wider accesses are ignored
        io_write(3'd2, 8'hFF, 2'd2);
        io_read(3'd2, 2'd0, b); check("R12", {24'h0, b}, 32'h20);
        io_read(3'd2, 2'd1, b); check("R12", {24'h0, b}, 32'h00);

        // R10 and R11 timer wrap
        io_write(3'd2, 8'h21, 2'd0);
        io_write(3'd1, 8'hFF, 2'd0);
        io_write(3'd0, 8'h01, 2'd0);
        prev = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 600 && !seen; k++) begin
            io_read(3'd0, 2'd0, b);
            if (b[0] && !prev) begin
                seen = 1'b1;
                check("R11", {31'h0, tmr_arm}, 32'h0);
                check("R9", {31'h0, sci}, 32'h1);
                io_read(3'd4, 2'd0, t1);
                check("R10", {24'h0, t1}, 32'h01);
            end
            prev = b[0];
        end
        check("R10", {31'h0, seen}, 32'h1);
        io_write(3'd0, 8'h01, 2'd0);
        check("R11", {31'h0, tmr_arm}, 32'h1);
        check("R9", {31'h0, sci}, 32'h0);
        io_read(3'd4, 2'd0, t1);
        repeat (9) @(negedge clk);
        io_read(3'd4, 2'd0, b); check("R10", {24'h0, b}, {24'h0, t1 + 8'd10});
        io_read(3'd5, 2'd0, b); check("R10", {24'h0, b}, 32'h0);
        io_read(3'd6, 2'd0, b); check("R10", {24'h0, b}, 32'h0);

        // R12 window closed while decode is off
        cfg_write(6'h20, 4'h1, 32'h0);
        check("R3", {31'h0, pm_dec_en}, 32'h0);
        io_write(3'd2, 8'h00, 2'd0);
        io_read(3'd2, 2'd0, b); check("R12", {24'h0, b}, 32'h0);
        cfg_write(6'h20, 4'h1, 32'h1);
        io_read(3'd2, 2'd0, b); check("R12", {24'h0, b}, 32'h21);

        // R5 SMBus decode off
        cfg_write(6'h34, 4'h4, 32'h000E_0000);
        check("R5", {31'h0, smb_dec_en}, 32'h0);
        cfg_read(6'h34, r); check("R5", r, 32'h000E_0000);

        // R1 reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cfg_read(6'h24, r); check("R1", r, 32'h1);
        cfg_read(6'h34, r); check("R1", r, 32'h0);
        cfg_read(6'h12, r); check("R1", r, 32'h1);
        check("R1", {29'h0, pm_dec_en, smb_dec_en, sci}, 32'h0);

        summary();
    end

endmodule